// File: doc/BRIEF.md
# Clock Multiplier Bring-Up Controller

This block owns the control of a times-four frequency multiplier that turns a 12 MHz reference into the 48 MHz clock that full-speed USB needs. Software reaches it through one 8-bit control and status register on a simple bus. The bus has an address-match select, a write strobe, write data and read data. The block drives the enable, initialize and source-select lines of the multiplier. It takes a lock indication back and reports it as a ready flag.

The block does more than store the register. It checks the bring-up order that the multiplier needs:
- clear the register;
- choose the source;
- raise enable;
- wait more than 5 µs;
- raise initialize;
- poll ready.

An out-of-order initialize request is not passed on to the multiplier. Instead it sets a sticky error flag. The same applies to a request for the reserved source code. The settle delay is counted in system clocks and is derived from a clock-frequency parameter. When an external oscillator feeds the multiplier, software must start it and let it settle before it issues initialize.

Top module: `clkmul_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `mul_en`, `mul_init` and `mul_src` are 0 and `err_flag` is 0.
- R2: Bit 7 of the register is enable and drives `mul_en`. Bits 1:0 select the source (00 internal oscillator, 01 external oscillator, 10 external oscillator halved, 11 reserved), drive `mul_src` and read back as written.
- R3: Bit 5 is the read-only ready flag. Bits 4:2 always read 0. Writes to bits 5:2 change nothing.
- R4: A write of 0x00 clears enable, initialize, the source and `err_flag`.
- R5: A write that sets enable and initialize together while enable is 0 raises enable only. Initialize stays 0 and `err_flag` is set.
- R6: A write of 1 to initialize while enable is 1 is forwarded only once SETTLE_CYC = floor(SYS_CLK_HZ·SETTLE_NS/1e9)+1 clocks have passed since the enable write. The forwarding write comes at least SETTLE_CYC+1 edges after the enable write. An earlier request is dropped and sets `err_flag`.
- R7: A write of 1 to initialize while enable is 0 leaves `mul_init` at 0 and sets `err_flag`.
- R8: A write whose source field is 11 clears enable and initialize, stores the 11 code and sets `err_flag`.
- R9: The ready bit (bit 5) is `mul_lock` passed through two flops. It reads 1 on the second edge after lock is seen, and is held at 0 unless enable and an accepted initialize are both in effect.
- R10: Clearing enable drops ready and `mul_init` by the edge of that write. A later enable restarts the settle delay.
- R11: `err_flag` stays set across any write other than 0x00.
- R12: With `bus_sel` low, writes are ignored and `bus_rdata` reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register address match |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not selected |
| mul_lock | input | 1 | Lock indication from the multiplier |
| mul_en | output | 1 | Multiplier enable |
| mul_init | output | 1 | Multiplier initialize |
| mul_src | output | 2 | Multiplier input source select |
| err_flag | output | 1 | Sticky sequencing error |

## Verification
Some properties are checked by assertions on every cycle:
- initialize is never high without enable;
- the reserved source never coexists with enable;
- the unused bits read 0;
- ready implies enable and initialize, and ready rises only two cycles after lock;
- the error flag is sticky;
- initialize never rises before the settle window, which the checker counts by itself.

Other behaviour can only be shown by the bench's scenarios:
- the exact edge at which an initialize request switches from rejected to accepted;
- the lock-to-ready latency;
- the restart of the delay after enable drops;
- the rejection of each illegal write.

// File: rtl/clkmul_ctrl.sv
module clkmul_ctrl #(
  parameter longint unsigned SYS_CLK_HZ = 250_000_000,
  parameter longint unsigned SETTLE_NS  = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       mul_lock,
  output logic       mul_en,
  output logic       mul_init,
  output logic [1:0] mul_src,
  output logic       err_flag
);
  localparam longint unsigned SETTLE_CYC = (SYS_CLK_HZ * SETTLE_NS) / 64'd1_000_000_000 + 64'd1;
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] SETTLE_W = CW'(SETTLE_CYC);
  localparam logic [1:0] SRC_RSV = 2'b11;

  logic          en_q, init_q, err_q;
  logic [1:0]    sel_q;
  logic [CW-1:0] cnt;
  logic          lk_s1, lk_s2;
  logic          wr, w_en, w_init, settled, ready;
  logic [1:0]    w_sel;

  assign wr      = bus_sel & bus_wr;
  assign w_en    = bus_wdata[7];
  assign w_init  = bus_wdata[6];
  assign w_sel   = bus_wdata[1:0];
  assign settled = (cnt == SETTLE_W);
  assign ready   = lk_s2 & en_q & init_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_s1 <= 1'b0;
      lk_s2 <= 1'b0;
    end else begin
      lk_s1 <= mul_lock;
      lk_s2 <= lk_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      init_q <= 1'b0;
      err_q  <= 1'b0;
      sel_q  <= 2'b00;
      cnt    <= '0;
    end else begin
      if (en_q && !settled) cnt <= cnt + 1'b1;
      if (wr) begin
        sel_q <= w_sel;
        if (w_sel == SRC_RSV) begin
          en_q   <= 1'b0;
          init_q <= 1'b0;
          cnt    <= '0;
          err_q  <= 1'b1;
        end else if (!w_en) begin
          en_q   <= 1'b0;
          init_q <= 1'b0;
          cnt    <= '0;
          if (bus_wdata == 8'h00) err_q <= 1'b0;
          else if (w_init)        err_q <= 1'b1;
        end else if (!en_q) begin
          en_q <= 1'b1;
          cnt  <= '0;
          if (w_init) err_q <= 1'b1;
        end else if (w_init && !init_q) begin
          if (settled) init_q <= 1'b1;
          else         err_q  <= 1'b1;
        end
      end
    end
  end

  assign mul_en    = en_q;
  assign mul_init  = init_q;
  assign mul_src   = sel_q;
  assign err_flag  = err_q;
  assign bus_rdata = bus_sel ? {en_q, init_q, ready, 3'b000, sel_q} : 8'h00;
endmodule

module clkmul_ctrl_chk #(
  parameter longint unsigned SETTLE = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       mul_lock,
  input logic       mul_en,
  input logic       mul_init,
  input logic [1:0] mul_src,
  input logic       err_flag,
  input logic       ready
);
  longint unsigned en_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               en_run <= 0;
    else if (!mul_en)         en_run <= 0;
    else if (en_run <= SETTLE) en_run <= en_run + 1;
  end

  a_r7_init_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    mul_init |-> mul_en);
  a_r8_reserved_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_src == 2'b11) |-> (!mul_en && !mul_init));
  a_r3_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> (bus_rdata[4:2] == 3'b000));
  a_r12_unselected_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == 8'h00));
  a_r9_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mul_en && mul_init));
  a_r9_ready_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(mul_lock, 2));
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(bus_sel && bus_wr && bus_wdata == 8'h00)) |=> err_flag);
  a_r6_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mul_init) |-> (en_run > SETTLE));
endmodule

bind clkmul_ctrl clkmul_ctrl_chk #(.SETTLE(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mul_lock(mul_lock),
  .mul_en(mul_en), .mul_init(mul_init), .mul_src(mul_src),
  .err_flag(err_flag), .ready(ready)
);

// File: tb/clkmul_ctrl_test.sv
module clkmul_ctrl_test;
  localparam int S = 1251;
  localparam int LOCK_DLY = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       mul_lock, mul_en, mul_init, err_flag;
  logic [1:0] mul_src;
  logic       lock_force = 1'b0;
  logic [7:0] lk_cnt;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  clkmul_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mul_lock(mul_lock),
    .mul_en(mul_en), .mul_init(mul_init), .mul_src(mul_src), .err_flag(err_flag)
  );

  always_ff @(posedge clk) begin
    if (!(mul_en && mul_init)) lk_cnt <= 8'd0;
    else if (lk_cnt < 8'(LOCK_DLY)) lk_cnt <= lk_cnt + 8'd1;
  end
  assign mul_lock = (lk_cnt == 8'(LOCK_DLY)) | lock_force;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] q);
    bus_sel = 1'b1; bus_wr = 1'b0; #1 q = bus_rdata; bus_sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] q;
    rd(q);
    chk("R1 rdata", q, 8'h00);
    chk("R1 outputs", {mul_en, mul_init, mul_src, err_flag}, 5'b0);
  endtask

  task automatic t_layout;
    logic [7:0] q;
    wr(8'h02); rd(q);
    chk("R2 readback", q, 8'h02);
    chk("R2 src", mul_src, 2'b10);
    wr(8'h01);
    chk("R2 src ext", mul_src, 2'b01);
    wr(8'h3D); rd(q);
    chk("R3 ignored bits", q, 8'h01);
    chk("R3 no err", err_flag, 1'b0);
    wr(8'h00);
  endtask

  task automatic t_init_no_en;
    logic [7:0] q;
    wr(8'h40); rd(q);
    chk("R7 init held", mul_init, 1'b0);
    chk("R7 err", err_flag, 1'b1);
    wr(8'h01);
    chk("R11 sticky", err_flag, 1'b1);
    wr(8'h00); rd(q);
    chk("R4 clear err", err_flag, 1'b0);
    chk("R4 clear reg", q, 8'h00);
  endtask

  task automatic t_init_with_en;
    wr(8'hC0);
    chk("R5 en", mul_en, 1'b1);
    chk("R5 init held", mul_init, 1'b0);
    chk("R5 err", err_flag, 1'b1);
    wr(8'h00);
    chk("R4 en cleared", mul_en, 1'b0);
  endtask

  task automatic t_reserved;
    wr(8'hC3);
    chk("R8 blocked", {mul_en, mul_init}, 2'b00);
    chk("R8 src", mul_src, 2'b11);
    chk("R8 err", err_flag, 1'b1);
    wr(8'h00);
  endtask

  task automatic t_early;
    wr(8'h80);
    repeat (S - 2) @(negedge clk);
    wr(8'hC0);
    chk("R6 early rejected", mul_init, 1'b0);
    chk("R6 early err", err_flag, 1'b1);
    wr(8'h00);
  endtask

  task automatic t_bringup;
    logic [7:0] q;
    wr(8'h01); wr(8'h81);
    repeat (S - 1) @(negedge clk);
    wr(8'hC1);
    chk("R6 accepted", mul_init, 1'b1);
    chk("R6 no err", err_flag, 1'b0);
    rd(q);
    chk("R9 not ready yet", q[5], 1'b0);
    for (int i = 0; i < 100 && !mul_lock; i++) @(negedge clk);
    rd(q); chk("R9 ready lag 0", q[5], 1'b0);
    @(negedge clk); rd(q); chk("R9 ready lag 1", q[5], 1'b0);
    @(negedge clk); rd(q); chk("R9 ready lag 2", q, 8'hE1);
    wr(8'h01); rd(q);
    chk("R10 ready dropped", q, 8'h01);
    chk("R10 init dropped", mul_init, 1'b0);
    wr(8'h81); wr(8'hC1);
    chk("R10 delay restarted", {mul_init, err_flag}, 2'b01);
    wr(8'h00);
  endtask

  task automatic t_lock_no_init;
    logic [7:0] q;
    wr(8'h80); lock_force = 1'b1;
    repeat (5) @(negedge clk);
    rd(q);
    chk("R9 lock without init", q[5], 1'b0);
    lock_force = 1'b0;
    wr(8'h00);
  endtask

  task automatic t_unselected;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = 8'h82;
    @(negedge clk); bus_wr = 1'b0;
    chk("R12 write ignored", {mul_en, mul_src}, 3'b000);
    #1 chk("R12 rdata zero", bus_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_layout;
    t_init_no_en;
    t_init_with_en;
    t_reserved;
    t_early;
    t_bringup;
    t_lock_no_init;
    t_unselected;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule